// File: doc/BRIEF.md
# Bit-Serial Clock and NVRAM Slave

This block is a small real-time-clock and non-volatile-memory slave that a host reaches through three bits of one of its own control registers. The bits are an enable, a serial clock and a data bit. While the enable is high, the host clocks one frame of sixteen bits. The first eight bits form a command and the last eight form a value. Bits are sampled on the falling edge of the serial clock, most significant bit first.

The command chooses the action. A read command makes the block drive the data line during the second byte, one bit per falling edge. The source can be a byte of the 32-byte RAM, the status byte, the control byte, or a BCD field of the time of day. A write command takes effect on the sixteenth edge. It either stores the value byte in RAM or, through a flag-clear command, clears two status flags and pulses a line that retires the pending clock interrupt. A one-second tick input advances a BCD seconds, minutes and hours counter. The date fields hold values given by parameters.

The frame logic is a four-state machine:
- `ST_IDLE`: the enable is low.
- `ST_CMD`: command bits are being shifted in.
- `ST_DATA`: value bits are being shifted in.
- `ST_DONE`: the frame is complete and further edges are ignored.

Its transitions are:
- **start**: `ST_IDLE` → `ST_CMD` one cycle after the enable rises.
- **cmd_full**: `ST_CMD` → `ST_DATA` on the eighth falling edge.
- **data_full**: `ST_DATA` → `ST_DONE` on the sixteenth falling edge.
- **abort**: any state → `ST_IDLE` when the enable is low.

The host must hold the enable high for at least one clock cycle before the first falling edge.

Top module: `rtc_ser_slave`

## Requirements
- R1: Driving the enable low clears the bit counter, the command byte and the value byte, and stops driving the data line. A frame that is cut short before its sixteenth edge writes nothing.
- R2: Bits are sampled only when the serial clock was high in the previous cycle and is low in the current one. Changes of the data input while the clock stays low or stays high have no effect.
- R3: The first eight falling edges shift the data input into the command byte, MSB first. The next eight shift it into the value byte, MSB first.
- R4: For commands 0x00 to 0x1F, RAM[command] is returned MSB first during the value phase. Each output bit appears, with the output enable high, one cycle after its falling edge. For commands outside the read ranges, the output enable stays low.
- R5: Command 0x30 returns the status byte. Command 0x31 returns the control byte.
- R6: Commands 0x20 to 0x2F return BCD time fields: 0x20 seconds, 0x21 minutes, 0x22 hours, 0x24 day of month, 0x25 month, 0x26 two-digit year. Every other code in that range returns 0x00.
- R7: On the sixteenth edge, a command from 0x80 to 0x9F writes the value byte into RAM[command − 0x80].
- R8: Command 0xB1 with value bit 2 set clears status bits 4 and 3 and pulses the clear output for exactly one cycle. With value bit 2 clear, neither happens.
- R9: After reset, the status byte is 0x90, the RAM holds the parameter image (byte i at bits 8i+7..8i), the data-line enable is low and the clear output is low.
- R10: Each tick advances the seconds field by one in BCD. Seconds wrap from 59 to 00 and carry into minutes, minutes wrap from 59 to 00 and carry into hours, and hours wrap from 23 to 00. Without a tick, the time does not change.
- R11: After the sixteenth edge, further falling edges change nothing until the enable drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Frame enable from the host |
| sclk_i | input | 1 | Serial clock bit from the host |
| sdi_i | input | 1 | Serial data from the host |
| tick_i | input | 1 | One-cycle pulse per elapsed second |
| sdo_o | output | 1 | Serial read data |
| sdo_oe_o | output | 1 | High while the block drives the data line |
| irq_clr_o | output | 1 | One-cycle pulse that retires the clock interrupt |

## Verification
Assertions check several rules on every cycle:
- the abort on a low enable, the frozen command after the frame ends, and the absence of shifting without a falling edge;
- that the output enable is confined to the value phase;
- the single-cycle clear pulse and the flags it must have cleared;
- the RAM write landing at the decoded address;
- that the time fields stay valid BCD within their ranges, and hold when there is no tick.

Only the bench's scenarios show the byte values that come back from each command range. They also show the MSB-first bit order, the ignoring of edges past the sixteenth, writes lost to an aborted frame, and the carry chain from seconds into hours at midnight.

// File: rtl/rtc_ser_pkg.sv
`timescale 1ns/1ps
package rtc_ser_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_DATA = 2'd2,
        ST_DONE = 2'd3
    } frame_st_e;

    localparam int          BYTE_W      = 8;
    localparam logic [7:0]  STATUS_RST  = 8'h90;
    localparam logic [7:0]  OP_STATUS   = 8'h30;
    localparam logic [7:0]  OP_CONTROL  = 8'h31;
    localparam logic [7:0]  OP_FLAGCLR  = 8'hB1;
    localparam logic [3:0]  TF_SEC      = 4'h0;
    localparam logic [3:0]  TF_MIN      = 4'h1;
    localparam logic [3:0]  TF_HOUR     = 4'h2;
    localparam logic [3:0]  TF_DAY      = 4'h4;
    localparam logic [3:0]  TF_MON      = 4'h5;
    localparam logic [3:0]  TF_YEAR     = 4'h6;
endpackage

// File: rtl/rtc_ser_frame.sv
`timescale 1ns/1ps
module rtc_ser_frame
    import rtc_ser_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         sclk_i,
    input  logic         sdi_i,
    input  logic [W-1:0] rd_byte_i,
    input  logic         rd_hit_i,
    output logic [W-1:0] cmd_o,
    output logic [W-1:0] val_o,
    output logic         wr_stb_o,
    output logic         sd_out_o,
    output logic         sd_oe_o
);
    localparam int              CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    frame_st_e        state, nxt;
    logic             sclk_q;
    logic             fall;
    logic [CNT_W-1:0] bitcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_i;
    end

    assign fall = sclk_q & ~sclk_i;

    // next-state logic
    always_comb begin
        nxt = state;
        if (!en_i) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: nxt = ST_CMD;
                ST_CMD:  if (fall && bitcnt == LAST) nxt = ST_DATA;
                ST_DATA: if (fall && bitcnt == LAST) nxt = ST_DONE;
                ST_DONE: nxt = ST_DONE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_o    <= '0;
            val_o    <= '0;
            bitcnt   <= '0;
            wr_stb_o <= 1'b0;
            sd_out_o <= 1'b0;
            sd_oe_o  <= 1'b0;
        end else if (!en_i) begin
            cmd_o    <= '0;
            val_o    <= '0;
            bitcnt   <= '0;
            wr_stb_o <= 1'b0;
            sd_out_o <= 1'b0;
            sd_oe_o  <= 1'b0;
        end else begin
            wr_stb_o <= 1'b0;
            unique case (state)
                ST_CMD: begin
                    if (fall) begin
                        cmd_o  <= {cmd_o[W-2:0], sdi_i};
                        bitcnt <= bitcnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (fall) begin
                        val_o  <= {val_o[W-2:0], sdi_i};
                        bitcnt <= bitcnt + 1'b1;
                        if (rd_hit_i) begin
                            sd_oe_o  <= 1'b1;
                            sd_out_o <= rd_byte_i[LAST - bitcnt];
                        end
                        if (bitcnt == LAST) wr_stb_o <= 1'b1;
                    end
                end
                ST_IDLE, ST_DONE: ;
            endcase
        end
    end

    p_abort_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (state == ST_IDLE && cmd_o == '0 && val_o == '0 && !sd_oe_o));

    p_edge_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && state == ST_CMD && !(sclk_q && !sclk_i)) |=> $stable(cmd_o));

    p_oe_scope_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sd_oe_o |-> (state == ST_DATA || state == ST_DONE));

    p_frame_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && en_i) |=> (state == ST_DONE && $stable(cmd_o) && $stable(val_o)));
endmodule

// File: rtl/rtc_ser_tod.sv
`timescale 1ns/1ps
module rtc_ser_tod #(
    parameter logic [7:0] SEC0 = 8'h00,
    parameter logic [7:0] MIN0 = 8'h00,
    parameter logic [7:0] HR0  = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hr_o
);
    localparam logic [7:0] SEC_TOP = 8'h59;
    localparam logic [7:0] HR_TOP  = 8'h23;

    // returns {wrapped, next value}
    function automatic logic [8:0] bcd_step(input logic [7:0] v, input logic [7:0] top);
        if (v == top)            return {1'b1, 8'h00};
        else if (v[3:0] == 4'h9) return {1'b0, v[7:4] + 4'h1, 4'h0};
        else                     return {1'b0, v + 8'h01};
    endfunction

    logic [8:0] s_nx, m_nx, h_nx;

    always_comb begin
        s_nx = bcd_step(sec_o, SEC_TOP);
        m_nx = bcd_step(min_o, SEC_TOP);
        h_nx = bcd_step(hr_o, HR_TOP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_o <= SEC0;
            min_o <= MIN0;
            hr_o  <= HR0;
        end else if (tick_i) begin
            sec_o <= s_nx[7:0];
            if (s_nx[8]) begin
                min_o <= m_nx[7:0];
                if (m_nx[8]) hr_o <= h_nx[7:0];
            end
        end
    end

    p_sec_bcd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> (sec_o[3:0] <= 4'h9 && sec_o[7:4] <= 4'h5 &&
                    min_o[3:0] <= 4'h9 && min_o[7:4] <= 4'h5));

    p_hr_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> (hr_o <= HR_TOP && hr_o[3:0] <= 4'h9));

    p_tick_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> ($stable(sec_o) && $stable(min_o) && $stable(hr_o)));
endmodule

// File: rtl/rtc_ser_slave.sv
`timescale 1ns/1ps
module rtc_ser_slave
    import rtc_ser_pkg::*;
#(
    parameter logic [255:0] RAM_INIT  = 256'h7e84_0000_0000_0000_0000_2000_4100_4b00_0000_6dfb_0000_0000_0340_0f94,
    parameter logic [7:0]   CTRL_INIT = 8'h00,
    parameter logic [7:0]   SEC0      = 8'h00,
    parameter logic [7:0]   MIN0      = 8'h00,
    parameter logic [7:0]   HR0       = 8'h00,
    parameter logic [7:0]   DAY0      = 8'h01,
    parameter logic [7:0]   MON0      = 8'h01,
    parameter logic [7:0]   YR0       = 8'h00
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic sclk_i,
    input  logic sdi_i,
    input  logic tick_i,
    output logic sdo_o,
    output logic sdo_oe_o,
    output logic irq_clr_o
);
    localparam int RAM_DEPTH = 32;
    localparam int AW        = $clog2(RAM_DEPTH);

    logic [BYTE_W-1:0] ram [RAM_DEPTH];
    logic [BYTE_W-1:0] status_q;
    logic [BYTE_W-1:0] cmd, val, rd_byte, tod_byte;
    logic [7:0]        sec, mins, hrs;
    logic              rd_hit, wr_stb;

    rtc_ser_frame #(.W(BYTE_W)) frame_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .sclk_i    (sclk_i),
        .sdi_i     (sdi_i),
        .rd_byte_i (rd_byte),
        .rd_hit_i  (rd_hit),
        .cmd_o     (cmd),
        .val_o     (val),
        .wr_stb_o  (wr_stb),
        .sd_out_o  (sdo_o),
        .sd_oe_o   (sdo_oe_o)
    );

    rtc_ser_tod #(.SEC0(SEC0), .MIN0(MIN0), .HR0(HR0)) tod_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .sec_o  (sec),
        .min_o  (mins),
        .hr_o   (hrs)
    );

    // time field select
    always_comb begin
        unique case (cmd[3:0])
            TF_SEC:  tod_byte = sec;
            TF_MIN:  tod_byte = mins;
            TF_HOUR: tod_byte = hrs;
            TF_DAY:  tod_byte = DAY0;
            TF_MON:  tod_byte = MON0;
            TF_YEAR: tod_byte = YR0;
            default: tod_byte = 8'h00;
        endcase
    end

    // read source decode by command range
    always_comb begin
        rd_hit  = 1'b1;
        rd_byte = 8'h00;
        if (cmd[7:5] == 3'b000)       rd_byte = ram[cmd[AW-1:0]];
        else if (cmd[7:4] == 4'h2)    rd_byte = tod_byte;
        else if (cmd == OP_STATUS)    rd_byte = status_q;
        else if (cmd == OP_CONTROL)   rd_byte = CTRL_INIT;
        else                          rd_hit  = 1'b0;
    end

    logic ram_wr, flag_clr;
    assign ram_wr   = wr_stb && (cmd[7:5] == 3'b100);
    assign flag_clr = wr_stb && (cmd == OP_FLAGCLR) && val[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < RAM_DEPTH; i++) ram[i] <= RAM_INIT[BYTE_W*i +: BYTE_W];
        end else if (ram_wr) begin
            ram[cmd[AW-1:0]] <= val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q  <= STATUS_RST;
            irq_clr_o <= 1'b0;
        end else begin
            irq_clr_o <= flag_clr;
            if (flag_clr) status_q[4:3] <= 2'b00;
        end
    end

    p_ram_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && cmd[7:5] == 3'b100) |=> (ram[$past(cmd[AW-1:0])] == $past(val)));

    p_clr_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr_o |=> !irq_clr_o);

    p_clr_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr_o |-> (status_q[4:3] == 2'b00));
endmodule

// File: tb/rtc_ser_slave_tb_top.sv
`timescale 1ns/1ps
module rtc_ser_slave_tb_top;
    localparam logic [255:0] INIT = 256'h1f2e3d4c_5b6a7988_97a6b5c4_d3e2f100_0123_4567_89ab_cdef_fedc_ba98_7654_3210;
    localparam logic [7:0]   CTRL = 8'h5A;
    localparam int           BASE_S = 23*3600 + 59*60 + 58;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, sclk = 1'b0, sdi = 1'b0, tick = 1'b0;
    logic sdo, sdo_oe, irq_clr;

    int n_cmp = 0, n_bad = 0, irq_cnt = 0, ticks = 0;
    logic [7:0] shadow [32];
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rtc_ser_slave #(
        .RAM_INIT(INIT), .CTRL_INIT(CTRL),
        .SEC0(8'h58), .MIN0(8'h59), .HR0(8'h23),
        .DAY0(8'h15), .MON0(8'h07), .YR0(8'h24)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en), .sclk_i(sclk), .sdi_i(sdi),
        .tick_i(tick), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .irq_clr_o(irq_clr)
    );

    always @(negedge clk) if (irq_clr) irq_cnt++;

    function automatic logic [7:0] to_bcd(input int x);
        return 8'(((x / 10) << 4) | (x % 10));
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp_v);
        n_cmp++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp_v);
        end
    endtask

    // Runs nbits falling edges: command, value, then extra bits.
    task automatic run(input logic [7:0] c, input logic [7:0] v, input int nbits,
                       input logic [7:0] extra, input bit noise,
                       output logic [7:0] rd, output logic oe_seen);
        logic [23:0] stream;
        stream = {c, v, extra};
        rd = 8'h00;
        oe_seen = 1'b0;
        @(negedge clk);
        en = 1'b1;
        for (int k = 0; k < nbits; k++) begin
            @(negedge clk);
            sdi = stream[23-k];
            sclk = 1'b1;
            repeat (2) @(negedge clk);
            sclk = 1'b0;
            @(negedge clk);
            if (k >= 8 && k < 16) begin
                rd = {rd[6:0], sdo};
                oe_seen = oe_seen | sdo_oe;
            end
            if (noise) begin
                repeat (2) begin
                    @(negedge clk);
                    sdi = ~sdi;
                end
            end
        end
        @(negedge clk);
        en = 1'b0;
        sdi = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic read_byte(input logic [7:0] c, output logic [7:0] rd, output logic oe);
        run(c, 8'h00, 16, 8'h00, 1'b0, rd, oe);
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        ticks++;
    endtask

    initial begin
        logic [7:0] rd;
        logic oe;
        int t;
        for (int i = 0; i < 32; i++) shadow[i] = INIT[8*i +: 8];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        check("R9 oe at reset", {7'd0, sdo_oe}, 8'h00);
        check("R9 clr at reset", {7'd0, irq_clr}, 8'h00);

        // R4 / R2 RAM read sweep, noise on odd addresses
        for (int a = 0; a < 32; a++) begin
            run(8'(a), 8'h00, 16, 8'h00, a[0], rd, oe);
            check("R4 ram read", rd, shadow[a]);
            check("R4 oe on read", {7'd0, oe}, 8'h01);
        end

        // R5 / R9 status and control
        read_byte(8'h30, rd, oe);
        check("R5 R9 status", rd, 8'h90);
        read_byte(8'h31, rd, oe);
        check("R5 control", rd, CTRL);

        // R6 time field sweep
        for (int c = 32'h20; c <= 32'h2F; c++) begin
            logic [7:0] e;
            case (c)
                32'h20: e = 8'h58;
                32'h21: e = 8'h59;
                32'h22: e = 8'h23;
                32'h24: e = 8'h15;
                32'h25: e = 8'h07;
                32'h26: e = 8'h24;
                default: e = 8'h00;
            endcase
            read_byte(8'(c), rd, oe);
            check("R6 time field", rd, e);
            check("R6 oe", {7'd0, oe}, 8'h01);
        end

        // R10 BCD rollover through midnight
        for (int n = 0; n < 66; n++) begin
            do_tick();
            if (n == 0 || n == 1 || n == 65) begin
                t = (BASE_S + ticks) % 86400;
                read_byte(8'h20, rd, oe);
                check("R10 seconds", rd, to_bcd(t % 60));
                read_byte(8'h21, rd, oe);
                check("R10 minutes", rd, to_bcd((t / 60) % 60));
                read_byte(8'h22, rd, oe);
                check("R10 hours", rd, to_bcd(t / 3600));
            end
        end
        // R10 no change without tick
        repeat (20) @(negedge clk);
        read_byte(8'h20, rd, oe);
        check("R10 hold", rd, to_bcd((BASE_S + ticks) % 60));

        // R7 / R3 write sweep, R4 no drive on writes
        for (int a = 0; a < 32; a++) begin
            logic [7:0] v;
            v = 8'((a * 7 + 3) ^ 8'hA5);
            run(8'h80 | 8'(a), v, 16, 8'h00, a[1], rd, oe);
            check("R4 no drive on write", {7'd0, oe}, 8'h00);
            shadow[a] = v;
        end
        for (int a = 0; a < 32; a++) begin
            read_byte(8'(a), rd, oe);
            check("R7 R3 write readback", rd, shadow[a]);
        end

        // R4 unmapped command not driven
        run(8'h40, 8'h00, 16, 8'h00, 1'b0, rd, oe);
        check("R4 unmapped no drive", {7'd0, oe}, 8'h00);

        // R8 flag clear
        run(8'hB1, 8'hFB, 16, 8'h00, 1'b0, rd, oe);
        read_byte(8'h30, rd, oe);
        check("R8 status untouched", rd, 8'h90);
        check("R8 no pulse", 8'(irq_cnt), 8'h00);
        run(8'hB1, 8'h04, 16, 8'h00, 1'b0, rd, oe);
        read_byte(8'h30, rd, oe);
        check("R8 status cleared", rd, 8'h80);
        check("R8 one pulse", 8'(irq_cnt), 8'h01);

        // R1 aborted write is lost, and the next frame starts clean
        run(8'h85, 8'h11, 12, 8'h00, 1'b0, rd, oe);
        read_byte(8'h05, rd, oe);
        check("R1 abort keeps ram", rd, shadow[5]);
        run(8'h80, 8'h00, 5, 8'h00, 1'b0, rd, oe);
        read_byte(8'h06, rd, oe);
        check("R1 clean restart", rd, shadow[6]);

        // R11 extra edges ignored
        run(8'h83, 8'h3C, 24, 8'hFF, 1'b0, rd, oe);
        shadow[3] = 8'h3C;
        read_byte(8'h03, rd, oe);
        check("R11 extra edges", rd, 8'h3C);
        read_byte(8'h1F, rd, oe);
        check("R11 others intact", rd, shadow[31]);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule